// File: doc/BRIEF.md
# GPIO Port Register Controller

This block places a row of general-purpose I/O pins behind a plain register bus. The bus has single-cycle read and write strobes, a word address and a write-data word. The register width is a build-time choice of 8, 16, 32 or 64 bits. Each register bit owns one pin. Software can drive the output latch in three ways:

- write the whole latch as a word;
- raise chosen bits through a set register;
- lower chosen bits through a clear register.

A single direction register decides which pins are driven.

Two build-time parameters change how the block behaves. The first picks the meaning of a 1 in the direction register: either "output" or "input". The second can reverse the bit-to-pin mapping, so that register bit b serves pin WIDTH-1-b. Input pins pass through a two-flop synchronizer before they are read back. The block has no pad cells: each pin is presented as an output value, an output enable and a sampled input.

The register offsets are: data at 0, set at 1, clear at 2 and direction at 3. Every other address is unmapped.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: After reset the output latch is zero and every pin is an input. This means pin_out = 0 and pin_oe = 0, and rd_data reads as 0.
- R2: A write to offset 0 loads the output latch with wr_data. pin_out shows the new latch after that clock edge.
- R3: A write to offset 1 forces high each latch bit where wr_data is 1. Latch bits where wr_data is 0 keep their value.
- R4: A write to offset 2 forces low each latch bit where wr_data is 1. Latch bits where wr_data is 0 keep their value.
- R5: With DIR_IN_POL = 0, the direction register resets to all zeros. A 1 in it makes the matching pin an output (pin_oe = 1).
- R6: With DIR_IN_POL = 1, the direction register resets to all ones. A 1 in it makes the matching pin an input (pin_oe = 0).
- R7: With REVERSE = 1, register bit b maps to pin WIDTH-1-b, for both driving and readback. With REVERSE = 0, register bit b maps to pin b.
- R8: Reading offset 0 returns the pin state. An output pin returns its latch bit. An input pin returns pin_in after two synchronizer flops, so a read strobed in the cycle a pin changes, or in the next cycle, still returns the old level. A read strobed on the third edge returns the new level.
- R9: Reading offset 1 returns the current output latch. Reading offset 3 returns the last direction word written, or the reset value. Reading offset 2 returns 0.
- R10: Reads of offsets 4 and above return 0. Writes to them change neither pin_out nor pin_oe.
- R11: rd_data is registered. It updates on the edge that samples rd_en, and it holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Word offset of the register |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Read data, valid the cycle after rd_en |
| pin_in | input | WIDTH | Sampled levels of the pins |
| pin_out | output | WIDTH | Value driven on each pin |
| pin_oe | output | WIDTH | Output enable for each pin |

## Verification
A corrupted output latch shows up on pin_out right after the edge that wrote it. It also shows up in the set-register readback one cycle after a read strobe. A wrong direction bit shows up at once on pin_oe, and it also changes which source the data readback takes for that pin. Faults in the synchronizer depth or in the bit mapping show up only through reads and the pin vectors. For that reason, latency is checked per edge after an input change, and the reversed build is checked with one asymmetric bit in each direction.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

    // Register offsets; the set/clear pair and data share the output latch.
    localparam int OFS_DATA = 0;
    localparam int OFS_SET  = 1;
    localparam int OFS_CLR  = 2;
    localparam int OFS_DIR  = 3;

    typedef enum logic [2:0] {
        SEL_DATA,
        SEL_SET,
        SEL_CLR,
        SEL_DIR,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [15:0] a);
        reg_sel_e s;
        if (a == 16'(OFS_DATA))      s = SEL_DATA;
        else if (a == 16'(OFS_SET))  s = SEL_SET;
        else if (a == 16'(OFS_CLR))  s = SEL_CLR;
        else if (a == 16'(OFS_DIR))  s = SEL_DIR;
        else                         s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw;
            stage2_q <= stage1_q;
        end
    end

    assign synced = stage2_q;

endmodule

// File: rtl/gpio_pin_map.sv
module gpio_pin_map #(
    parameter int WIDTH   = 8,
    parameter bit REVERSE = 1'b0
) (
    input  logic [WIDTH-1:0] reg_out,
    input  logic [WIDTH-1:0] reg_oe,
    input  logic [WIDTH-1:0] pin_level,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] reg_level
);
    for (genvar n = 0; n < WIDTH; n++) begin : g_pin
        localparam int BIT = REVERSE ? (WIDTH - 1 - n) : n;
        assign pin_out[n]     = reg_out[BIT];
        assign pin_oe[n]      = reg_oe[BIT];
        assign reg_level[BIT] = pin_level[n];
    end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_mmio_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int ADDR_W     = 3,
    parameter bit DIR_IN_POL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  level_in,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  drive_mask,
    output logic [WIDTH-1:0]  rd_data
);
    localparam logic [WIDTH-1:0] DIR_RESET = DIR_IN_POL ? '1 : '0;

    reg_sel_e         sel;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] state_view;

    assign sel        = decode_addr(16'(addr));
    assign drive_mask = DIR_IN_POL ? ~dir_q : dir_q;
    assign state_view = (drive_mask & latch_q) | (~drive_mask & level_in);

    // Output latch: full load, bitwise set, bitwise clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA: latch_q <= wr_data;
                SEL_SET:  latch_q <= latch_q | wr_data;
                SEL_CLR:  latch_q <= latch_q & ~wr_data;
                default:  latch_q <= latch_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_RESET;
        end else if (wr_en && sel == SEL_DIR) begin
            dir_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_DATA: rd_data <= state_view;
                SEL_SET:  rd_data <= latch_q;
                SEL_DIR:  rd_data <= dir_q;
                default:  rd_data <= '0;
            endcase
        end
    end

    assert_set_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SET) |=> ((latch_q & $past(wr_data)) == $past(wr_data)));

    assert_set_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SET) |=>
            ((latch_q & ~$past(wr_data)) == ($past(latch_q) & ~$past(wr_data))));

    assert_clr_lowers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CLR) |=> ((latch_q & $past(wr_data)) == '0));

    assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> ($stable(latch_q) && $stable(dir_q)));

    assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl #(
    parameter int WIDTH      = 8,
    parameter int ADDR_W     = 3,
    parameter bit DIR_IN_POL = 1'b0,
    parameter bit REVERSE    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);
    if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
        $fatal(1, "WIDTH must be 8, 16, 32 or 64");
    end

    logic [WIDTH-1:0] pin_synced;
    logic [WIDTH-1:0] reg_level;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] drive_mask;

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (pin_synced)
    );

    gpio_pin_map #(.WIDTH(WIDTH), .REVERSE(REVERSE)) u_map (
        .reg_out   (latch_q),
        .reg_oe    (drive_mask),
        .pin_level (pin_synced),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .reg_level (reg_level)
    );

    gpio_regfile #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_IN_POL(DIR_IN_POL)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .level_in   (reg_level),
        .latch_q    (latch_q),
        .drive_mask (drive_mask),
        .rd_data    (rd_data)
    );

    // Pins that are not driven must show a zero output value only via the latch;
    // the enable vector itself must clear during reset.
    assert_reset_inputs_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0));

endmodule

// File: tb/gpio_mmio_ctrl_test.sv
module gpio_mmio_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_a = 0, rd_a = 0, wr_b = 0, rd_b = 0;
    logic [2:0] addr_a = '0, addr_b = '0;
    logic [7:0] wd_a = '0, wd_b = '0;
    logic [7:0] pin_in_a = 8'hA5, pin_in_b = 8'h01;
    logic [7:0] rdata_a, rdata_b, pout_a, pout_b, poe_a, poe_b;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #4 clk = ~clk;

    gpio_mmio_ctrl #(.WIDTH(8), .ADDR_W(3), .DIR_IN_POL(1'b0), .REVERSE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .rd_en(rd_a), .addr(addr_a),
        .wr_data(wd_a), .rd_data(rdata_a), .pin_in(pin_in_a),
        .pin_out(pout_a), .pin_oe(poe_a)
    );

    gpio_mmio_ctrl #(.WIDTH(8), .ADDR_W(3), .DIR_IN_POL(1'b1), .REVERSE(1'b1)) uut_rev (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .rd_en(rd_b), .addr(addr_b),
        .wr_data(wd_b), .rd_data(rdata_b), .pin_in(pin_in_b),
        .pin_out(pout_b), .pin_oe(poe_b)
    );

    typedef struct packed {
        logic       is_rd;
        logic [2:0] a;
        logic [7:0] d;
        logic [7:0] exp;     // pin_out after a write, rd_data after a read
        logic [7:0] exp_oe;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'd0, 8'h3C, 8'h3C, 8'h00, 4'd2},
        '{1'b0, 3'd1, 8'h81, 8'hBD, 8'h00, 4'd3},
        '{1'b0, 3'd2, 8'h0C, 8'hB1, 8'h00, 4'd4},
        '{1'b0, 3'd3, 8'hF0, 8'hB1, 8'hF0, 4'd5},
        '{1'b1, 3'd1, 8'h00, 8'hB1, 8'hF0, 4'd9},
        '{1'b1, 3'd3, 8'h00, 8'hF0, 8'hF0, 4'd9},
        '{1'b1, 3'd0, 8'h00, 8'hB5, 8'hF0, 4'd8},
        '{1'b0, 3'd5, 8'hFF, 8'hB1, 8'hF0, 4'd10},
        '{1'b1, 3'd6, 8'h00, 8'h00, 8'hF0, 4'd10},
        '{1'b1, 3'd2, 8'h00, 8'h00, 8'hF0, 4'd9},
        '{1'b0, 3'd1, 8'h00, 8'hB1, 8'hF0, 4'd3},
        '{1'b0, 3'd2, 8'hFF, 8'h00, 8'hF0, 4'd4},
        '{1'b0, 3'd0, 8'hFF, 8'hFF, 8'hF0, 4'd2}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic bus_wr(input bit rev, input logic [2:0] a, input logic [7:0] d);
        if (rev) begin wr_b = 1; addr_b = a; wd_b = d; end
        else     begin wr_a = 1; addr_a = a; wd_a = d; end
        @(posedge clk);
        @(negedge clk);
        wr_a = 0; wr_b = 0;
    endtask

    task automatic bus_rd(input bit rev, input logic [2:0] a);
        if (rev) begin rd_b = 1; addr_b = a; end
        else     begin rd_a = 1; addr_a = a; end
        @(posedge clk);
        @(negedge clk);
        rd_a = 0; rd_b = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state on both builds
        check("R1", "pin_out", pout_a, 8'h00);
        check("R1", "pin_oe", poe_a, 8'h00);
        check("R1", "rd_data", rdata_a, 8'h00);
        check("R1", "rev pin_oe", poe_b, 8'h00);

        // Table walk on the default build
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].is_rd) begin
                bus_rd(1'b0, TBL[i].a);
                check(tag_name(TBL[i].tag), "rd_data", rdata_a, TBL[i].exp);
            end else begin
                bus_wr(1'b0, TBL[i].a, TBL[i].d);
                check(tag_name(TBL[i].tag), "pin_out", pout_a, TBL[i].exp);
            end
            check(tag_name(TBL[i].tag), "pin_oe", poe_a, TBL[i].exp_oe);
        end

        // R11: rd_data holds across a write without a read
        bus_rd(1'b0, 3'd1);
        check("R11", "rd_data after read", rdata_a, 8'hFF);
        bus_wr(1'b0, 3'd2, 8'h0F);
        check("R11", "rd_data held", rdata_a, 8'hFF);
        check("R4", "pin_out", pout_a, 8'hF0);

        // R8: two-flop latency on input pins
        bus_wr(1'b0, 3'd3, 8'h00);
        check("R5", "pin_oe all input", poe_a, 8'h00);
        pin_in_a = 8'h5A;
        bus_rd(1'b0, 3'd0);
        check("R8", "read same cycle", rdata_a, 8'hA5);
        bus_rd(1'b0, 3'd0);
        check("R8", "read next cycle", rdata_a, 8'hA5);
        bus_rd(1'b0, 3'd0);
        check("R8", "read third edge", rdata_a, 8'h5A);

        // R6 / R7 on the input-polarity, reversed build
        bus_rd(1'b1, 3'd3);
        check("R6", "dir reset", rdata_b, 8'hFF);
        bus_wr(1'b1, 3'd3, 8'hFE);
        check("R6", "pin_oe", poe_b, 8'h80);
        bus_wr(1'b1, 3'd0, 8'h01);
        check("R7", "pin_out", pout_b, 8'h80);
        bus_rd(1'b1, 3'd0);
        check("R7", "data readback", rdata_b, 8'h81);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule